// File: doc/BRIEF.md
# CCD Horizontal Readout Clock Sequencer

This block drives the horizontal side of a CCD line readout. A strobe from the vertical sequencer starts a line. After a fixed settling delay the block runs a fixed number of horizontal counts. For each count it produces two complementary register clocks, a reset-gate pulse and the two strobes used by correlated double sampling. The first CDS strobe clamps the reset reference level. The second samples the video level after the charge packet has been dumped.

The master clock runs at four times the pixel rate, so every pixel is divided into four phases, numbered 0 to 3. Phase 0 is the phase in which H2 rises. The phase that carries each CDS strobe is taken from a two-bit input when a line is accepted. A downstream digitizer receives a pixel count and three region flags with every pixel, so it can tag each sample. Each line has leading empty register stages, active pixels, dark reference columns and trailing empty counts. A one-cycle done pulse closes the line. A new line may be requested in the very last master clock of the current line, which gives back-to-back lines.

Top module: `ccd_hclk_gen`

## Requirements
- R1: During and after reset, with no line running, h1=1, h2=0, rst_gate=0, cds_clamp=0, cds_sample=0, line_done=0, pix_count=0 and all three region flags are 0.
- R2: A line_start seen high on a clock edge while idle is accepted. The outputs keep their idle levels for HDELAY clocks after that edge (default 304, about 5.3 us at 57.28 MHz). The first pixel phase appears on the outputs HDELAY+1 clocks after the accepting edge.
- R3: Each pixel lasts exactly 4 clocks. h2 is 1 in phases 0 and 1 and 0 in phases 2 and 3, and h1 is always the complement of h2, so the charge dump (the falling edge of h2) falls between phase 1 and phase 2.
- R4: rst_gate is 1 for exactly one clock per pixel, in phase 0. It rises on the same clock edge as h2.
- R5: cds_clamp is 1 for exactly one clock per pixel, in the phase whose index equals the captured clamp_ph value (0..3). cds_sample behaves the same way for sample_ph. Equal values make both strobes fire in the same clock.
- R6: clamp_ph and sample_ph are captured only on the edge that accepts a line. Changing them during a line has no effect on that line's strobes.
- R7: pix_count is 1 for the first pixel and counts up by one at every pixel start (rising edge of rst_gate), up to 791. It holds its value for all four phases of a pixel.
- R8: While a line runs, exactly one flag is set. is_empty is set for counts 1..8 and 789..791, is_active for 9..776, and is_dark for 777..788.
- R9: On the clock after phase 3 of count 791, the outputs return to their idle levels and line_done is 1 for exactly one clock.
- R10: A line_start during the delay or during any clock of a line other than its last clock is ignored. The running line's timing and the idle state after it do not change.
- R11: A line_start seen on the edge that ends phase 3 of count 791 is accepted. line_done still pulses on the next clock, and the new line's first pixel appears HDELAY+1 clocks after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Request to read out one line |
| clamp_ph | input | 2 | Pixel phase for the reset-level clamp strobe |
| sample_ph | input | 2 | Pixel phase for the video sample strobe |
| h1 | output | 1 | Horizontal register clock, phase 1 |
| h2 | output | 1 | Horizontal register clock, phase 2 |
| rst_gate | output | 1 | Floating-node reset pulse |
| cds_clamp | output | 1 | CDS reference clamp strobe |
| cds_sample | output | 1 | CDS video sample strobe |
| pix_count | output | 10 | Horizontal count of the current pixel, 0 when idle |
| is_empty | output | 1 | Current count is an empty register stage |
| is_active | output | 1 | Current count is an active pixel |
| is_dark | output | 1 | Current count is a dark reference column |
| line_done | output | 1 | One-clock pulse after the final count |

## Verification
The end of a line and the acceptance of the next line can fall in the same clock. The bench provokes this by raising line_start exactly on the final phase of count 791. It then checks that line_done still appears on the following clock with idle levels. It also checks that the next line's first pixel lands HDELAY+1 clocks after the accepting edge, using the CDS phases that were present at that edge. The two CDS strobes can also share a clock. Random phase settings include equal values, and the bench expects both strobes high together in that phase.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DELAY = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_t;

  typedef logic [1:0] phase_t;

  typedef struct packed {
    phase_t clamp;
    phase_t sample;
  } cds_cfg_t;

  localparam phase_t PH_FIRST = 2'd0;
  localparam phase_t PH_LAST  = 2'd3;

endpackage

// File: rtl/hclk_sequencer.sv
module hclk_sequencer
  import hclk_pkg::*;
#(
  parameter int HDELAY    = 304,
  parameter int PIX_TOTAL = 791,
  localparam int PW = $clog2(PIX_TOTAL + 1),
  localparam int DW = $clog2(HDELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  cds_cfg_t      cfg_in,
  output logic          run,
  output phase_t        phase,
  output logic [PW-1:0] pix,
  output cds_cfg_t      cfg,
  output logic          end_pulse
);

  localparam logic [PW-1:0] PIX_LAST  = PW'(PIX_TOTAL);
  localparam logic [DW-1:0] DLY_LAST  = DW'(HDELAY - 1);

  seq_state_t    state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  phase_t        ph_q, ph_d;
  logic [PW-1:0] pix_q, pix_d;
  cds_cfg_t      cfg_q, cfg_d;
  logic          end_q, end_d;
  logic          last_clk, accept, cfg_en;

  assign last_clk = (state_q == SQ_RUN) && (ph_q == PH_LAST) && (pix_q == PIX_LAST);
  assign accept   = line_start && ((state_q == SQ_IDLE) || last_clk);
  assign cfg_en   = accept;

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    ph_d    = ph_q;
    pix_d   = pix_q;
    end_d   = last_clk;
    cfg_d   = cfg_en ? cfg_in : cfg_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          state_d = SQ_DELAY;
          dcnt_d  = '0;
        end
      end
      SQ_DELAY: begin
        if (dcnt_q == DLY_LAST) begin
          state_d = SQ_RUN;
          ph_d    = PH_FIRST;
          pix_d   = PW'(1);
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      SQ_RUN: begin
        ph_d = ph_q + 1'b1;
        if (ph_q == PH_LAST) begin
          if (pix_q == PIX_LAST) begin
            pix_d   = '0;
            dcnt_d  = '0;
            state_d = accept ? SQ_DELAY : SQ_IDLE;
          end else begin
            pix_d = pix_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dcnt_q  <= '0;
      ph_q    <= PH_FIRST;
      pix_q   <= '0;
      cfg_q   <= '0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      ph_q    <= ph_d;
      pix_q   <= pix_d;
      cfg_q   <= cfg_d;
      end_q   <= end_d;
    end
  end

  assign run       = (state_q == SQ_RUN);
  assign phase     = ph_q;
  assign pix       = pix_q;
  assign cfg       = cfg_q;
  assign end_pulse = end_q;

endmodule

// File: rtl/hclk_region_dec.sv
module hclk_region_dec #(
  parameter int N_LEAD  = 8,
  parameter int N_ACT   = 768,
  parameter int N_DARK  = 12,
  parameter int N_TRAIL = 3,
  localparam int TOTAL  = N_LEAD + N_ACT + N_DARK + N_TRAIL,
  localparam int PW     = $clog2(TOTAL + 1)
) (
  input  logic [PW-1:0] pix,
  output logic          in_empty,
  output logic          in_active,
  output logic          in_dark
);

  localparam int ACT_FIRST   = N_LEAD + 1;
  localparam int DARK_FIRST  = ACT_FIRST + N_ACT;
  localparam int TRAIL_FIRST = DARK_FIRST + N_DARK;

  logic lead_zone, trail_zone;

  always_comb begin
    lead_zone  = (pix >= PW'(1)) && (pix < PW'(ACT_FIRST));
    trail_zone = (pix >= PW'(TRAIL_FIRST)) && (pix <= PW'(TOTAL));
    in_empty   = lead_zone || trail_zone;
    in_active  = (pix >= PW'(ACT_FIRST)) && (pix < PW'(DARK_FIRST));
    in_dark    = (pix >= PW'(DARK_FIRST)) && (pix < PW'(TRAIL_FIRST));
  end

endmodule

// File: rtl/hclk_out_stage.sv
module hclk_out_stage
  import hclk_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  phase_t        phase,
  input  logic [PW-1:0] pix,
  input  logic [2:0]    region,
  input  cds_cfg_t      cfg,
  input  logic          end_pulse,
  output logic          h1,
  output logic          h2,
  output logic          rst_gate,
  output logic          cds_clamp,
  output logic          cds_sample,
  output logic [PW-1:0] pix_count,
  output logic [2:0]    region_q,
  output logic          line_done
);

  logic          h2_d, rg_d, cl_d, sm_d, dn_d;
  logic [PW-1:0] pc_d;
  logic [2:0]    rq_d;

  always_comb begin
    h2_d = run && !phase[1];
    rg_d = run && (phase == PH_FIRST);
    cl_d = run && (phase == cfg.clamp);
    sm_d = run && (phase == cfg.sample);
    pc_d = run ? pix : '0;
    rq_d = run ? region : 3'b000;
    dn_d = end_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1         <= 1'b1;
      h2         <= 1'b0;
      rst_gate   <= 1'b0;
      cds_clamp  <= 1'b0;
      cds_sample <= 1'b0;
      pix_count  <= '0;
      region_q   <= 3'b000;
      line_done  <= 1'b0;
    end else begin
      h1         <= !h2_d;
      h2         <= h2_d;
      rst_gate   <= rg_d;
      cds_clamp  <= cl_d;
      cds_sample <= sm_d;
      pix_count  <= pc_d;
      region_q   <= rq_d;
      line_done  <= dn_d;
    end
  end

endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen
  import hclk_pkg::*;
#(
  parameter int HDELAY  = 304,
  parameter int N_LEAD  = 8,
  parameter int N_ACT   = 768,
  parameter int N_DARK  = 12,
  parameter int N_TRAIL = 3,
  localparam int PIX_TOTAL = N_LEAD + N_ACT + N_DARK + N_TRAIL,
  localparam int PIX_W     = $clog2(PIX_TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [1:0]       clamp_ph,
  input  logic [1:0]       sample_ph,
  output logic             h1,
  output logic             h2,
  output logic             rst_gate,
  output logic             cds_clamp,
  output logic             cds_sample,
  output logic [PIX_W-1:0] pix_count,
  output logic             is_empty,
  output logic             is_active,
  output logic             is_dark,
  output logic             line_done
);

  cds_cfg_t         cfg_in, cfg_run;
  logic             run, end_pulse;
  phase_t           phase;
  logic [PIX_W-1:0] pix;
  logic             z_empty, z_active, z_dark;
  logic [2:0]       region_q;

  assign cfg_in.clamp  = clamp_ph;
  assign cfg_in.sample = sample_ph;

  hclk_sequencer #(
    .HDELAY    (HDELAY),
    .PIX_TOTAL (PIX_TOTAL)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .cfg_in     (cfg_in),
    .run        (run),
    .phase      (phase),
    .pix        (pix),
    .cfg        (cfg_run),
    .end_pulse  (end_pulse)
  );

  hclk_region_dec #(
    .N_LEAD  (N_LEAD),
    .N_ACT   (N_ACT),
    .N_DARK  (N_DARK),
    .N_TRAIL (N_TRAIL)
  ) u_reg (
    .pix       (pix),
    .in_empty  (z_empty),
    .in_active (z_active),
    .in_dark   (z_dark)
  );

  hclk_out_stage #(
    .PW (PIX_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .phase      (phase),
    .pix        (pix),
    .region     ({z_empty, z_active, z_dark}),
    .cfg        (cfg_run),
    .end_pulse  (end_pulse),
    .h1         (h1),
    .h2         (h2),
    .rst_gate   (rst_gate),
    .cds_clamp  (cds_clamp),
    .cds_sample (cds_sample),
    .pix_count  (pix_count),
    .region_q   (region_q),
    .line_done  (line_done)
  );

  assign is_empty  = region_q[2];
  assign is_active = region_q[1];
  assign is_dark   = region_q[0];

endmodule

// File: rtl/hclk_checker.sv
module hclk_checker #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h1,
  input logic          h2,
  input logic          rst_gate,
  input logic          cds_clamp,
  input logic          cds_sample,
  input logic [PW-1:0] pix_count,
  input logic          is_empty,
  input logic          is_active,
  input logic          is_dark,
  input logic          line_done
);

  AST_H_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    h1 != h2); // R3

  AST_RST_ON_H2_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_gate) |-> $rose(h2)); // R4

  AST_RST_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_gate |=> !rst_gate); // R4

  AST_CLAMP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cds_clamp || cds_sample) |-> (pix_count != '0)); // R5

  AST_PIX_STEP_AT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    ((pix_count != $past(pix_count)) && (pix_count != '0)) |-> $rose(rst_gate)); // R7

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_count != '0) |-> ($countones({is_empty, is_active, is_dark}) == 1)); // R8

  AST_NO_REGION_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_count == '0) |-> $onehot0({is_empty, is_active, is_dark}) && !is_active && !is_dark && !is_empty); // R1

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (h1 && !h2 && (pix_count == '0))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done); // R9

endmodule

bind ccd_hclk_gen hclk_checker #(.PW(PIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h1         (h1),
  .h2         (h2),
  .rst_gate   (rst_gate),
  .cds_clamp  (cds_clamp),
  .cds_sample (cds_sample),
  .pix_count  (pix_count),
  .is_empty   (is_empty),
  .is_active  (is_active),
  .is_dark    (is_dark),
  .line_done  (line_done)
);

// File: tb/ccd_hclk_gen_tb.sv
module ccd_hclk_gen_tb;

  localparam int HDELAY  = 304;
  localparam int NPIX    = 791;
  localparam int LASTK   = NPIX * 4 - 1;

  logic       clk;
  logic       rst_n;
  logic       line_start;
  logic [1:0] clamp_ph;
  logic [1:0] sample_ph;
  logic       h1, h2, rg, cl, sm, ld;
  logic [9:0] pc;
  logic       f_e, f_a, f_d;

  int checks = 0;
  int fails  = 0;

  ccd_hclk_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .clamp_ph   (clamp_ph),
    .sample_ph  (sample_ph),
    .h1         (h1),
    .h2         (h2),
    .rst_gate   (rg),
    .cds_clamp  (cl),
    .cds_sample (sm),
    .pix_count  (pc),
    .is_empty   (f_e),
    .is_active  (f_a),
    .is_dark    (f_d),
    .line_done  (ld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_flags(input int p);
    if (p >= 9 && p <= 776)        return 3'b010;
    else if (p >= 777 && p <= 788) return 3'b001;
    else                           return 3'b100;
  endfunction

  task automatic chk_idle(input string req, input logic want_done);
    chk(req, {h1, h2, rg, cl, sm}, 5'b10000);
    chk(req, pc, 0);
    chk(req, {f_e, f_a, f_d}, 3'b000);
    chk(req, ld, want_done);
  endtask

  // Precondition: at the negedge right after the edge that accepted line_start.
  task automatic check_line(input bit prev_done, input bit chain, input bit disturb);
    logic [1:0] cfg_c, cfg_s;
    int j;
    cfg_c = clamp_ph;
    cfg_s = sample_ph;
    j = disturb ? (8 + int'($urandom % 3100)) : -10;
    for (int i = 1; i <= HDELAY; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 1) chk_idle(prev_done ? "R11" : "R2", prev_done);
      else if (i == HDELAY || i == 2) chk_idle("R2", 1'b0);
    end
    for (int k = 0; k <= LASTK; k++) begin
      int p, q;
      @(posedge clk); @(negedge clk);
      p = k / 4 + 1;
      q = k % 4;
      chk("R3", {h1, h2}, (q < 2) ? 2'b01 : 2'b10);
      chk("R4", rg, q == 0);
      chk(disturb ? "R6" : "R5", {cl, sm}, {q == int'(cfg_c), q == int'(cfg_s)});
      chk("R7", pc, p);
      chk("R8", {f_e, f_a, f_d}, exp_flags(p));
      if (k == 0) chk(prev_done ? "R11" : "R2", ld, 1'b0);
      if (k == j) begin
        clamp_ph   = 2'($urandom);
        sample_ph  = 2'($urandom);
        line_start = 1'b1;
      end
      if (k == j + 1) line_start = 1'b0;
      if (chain && k == LASTK - 1) line_start = 1'b1;
      if (k == LASTK) line_start = 1'b0;
    end
  endtask

  task automatic start_line();
    line_start = 1'b1;
    @(posedge clk); @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic end_check(input string req);
    @(posedge clk); @(negedge clk);
    chk_idle("R9", 1'b1);
    @(posedge clk); @(negedge clk);
    chk_idle(req, 1'b0);
    repeat (5) begin
      @(posedge clk); @(negedge clk);
    end
    chk_idle(req, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    rst_n      = 1'b0;
    line_start = 1'b0;
    clamp_ph   = 2'd1;
    sample_ph  = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1", 1'b0);
    line_start = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_idle("R1", 1'b0);
    line_start = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1", 1'b0);

    // Directed line: clamp in phase 1, sample in phase 3.
    start_line();
    check_line(1'b0, 1'b0, 1'b0);
    end_check("R9");

    // Disturbed line chained into a following line (R10, R6, R11).
    clamp_ph  = 2'd1;
    sample_ph = 2'd2;
    start_line();
    check_line(1'b0, 1'b1, 1'b1);
    check_line(1'b1, 1'b0, 1'b0);
    end_check("R10");

    // Equal strobe phases: both fire in one clock (R5).
    clamp_ph  = 2'd2;
    sample_ph = 2'd2;
    start_line();
    check_line(1'b0, 1'b0, 1'b0);
    end_check("R9");

    // Random settings, random disturbance and random chaining.
    for (int n = 0; n < 3; n++) begin
      bit ch;
      clamp_ph  = 2'($urandom);
      sample_ph = 2'($urandom);
      ch = 1'($urandom);
      start_line();
      check_line(1'b0, ch, 1'($urandom));
      if (ch) check_line(1'b1, 1'b0, 1'($urandom));
      end_check("R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule